// File: doc/BRIEF.md
# Two-Step Key Write Guard

This block sits in front of a bank of configuration registers and decides, write by write, whether each one may land. Software opens the bank by writing two key words to a dedicated key address in a fixed order. The bank then stays open for exactly one further write. That write is accepted, and any write at all, wherever it goes, closes the bank again. The guard's progress through the sequence can be read back at the key address as a small state code.

A second, independent protection sits on top of the key. One bit of the lock-control register (register index 1, bit 31) is a sticky lock. Once an accepted write sets it, it refuses every write to a fixed subset of registers, whether or not the key sequence is complete. Only reset clears it. The protected registers are outside this block. The block drives one write-allow line per register, and the register file qualifies its own write enable with that line.

Top module: `keyGuard`

## Requirements
- R1: After reset the state code reads 0 (locked), the sticky lock reads 0 and no write-allow line is high.
- R2: While locked, writing the full word 0x000000A5 to the key address (12) moves the state to 1 (intermediate). No write-allow line rises for that write.
- R3: While intermediate, writing the full word 0x000000F1 to the key address moves the state to 2 (open).
- R4: While intermediate, any other write returns the state to 0 and raises no write-allow line. This covers a different key word or a write to any register.
- R5: While open, a write to register index i (0 to 7) raises write-allow bit i alone, in the same cycle as the write strobe, unless R10 blocks it. After any write of any address, the state reads 0 again.
- R6: While open, a write to the key address returns the state to 0, even when the word is 0x000000A5.
- R7: While locked, register writes and key writes of any word other than 0x000000A5 raise no write-allow line, and the state stays 0.
- R8: A write-allow line is high only while the write strobe is high, and at most one line is high at a time.
- R9: An allowed write to register index 1 with data bit 31 set sets the sticky lock. A read of address 1 then returns bit 31 set and all other bits 0.
- R10: While the sticky lock is set, writes to register indices 1, 2, 4, 5, 6 and 7 are refused even when open. Such a refused write still closes the bank. Writes to indices 0 and 3 are still allowed when open.
- R11: Once set, the sticky lock stays set until reset. Writes that try to clear it change nothing.
- R12: Reads return the state code in bits 1:0 of the key address, with all other bits 0. Reads of any address other than 12 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one write per high cycle |
| wrAddr | input | 4 | Write word address |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Read word address |
| rdData | output | 32 | Read data: state code or sticky lock |
| wrAllow | output | 8 | Per-register write permission |
| stickyLock | output | 1 | Current sticky lock value |

## Verification
Two functions can act in one write. Suppose the bank is open and the next write goes to register 1 with bit 31 set. That write consumes the key opening, so the bank closes. The same write also sets the sticky lock. The bench provokes this by running the two-key sequence and then writing 0x80000000 to index 1. It judges the outcome in three ways: the write-allow line for index 1 must be high during that write, the state readback must return to 0 afterwards, and the lock readback at address 1 must show bit 31. A later reopened write to a masked register then shows that the lock persisted independently of the key.

// File: rtl/key_guard_pkg.sv
package key_guard_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_MID    = 2'd1,
    ST_OPEN   = 2'd2
  } guardState_e;

  typedef struct packed {
    logic        writeOpen;
    guardState_e state;
  } ctrlStrobe_t;
endpackage

// File: rtl/keyGuardCtrl.sv
module keyGuardCtrl
  import key_guard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int KEY_ADDR = 12,
  parameter logic [DATA_W-1:0] KEY_FIRST = 32'h0000_00A5,
  parameter logic [DATA_W-1:0] KEY_SECOND = 32'h0000_00F1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobe_t       strobes
);
  localparam logic [ADDR_W-1:0] KeyAddrL = ADDR_W'(KEY_ADDR);

  guardState_e stateQ, stateD;
  logic keyHit;

  assign keyHit = wrEn && (wrAddr == KeyAddrL);

  always_comb begin
    stateD = stateQ;
    if (wrEn) begin
      unique case (stateQ)
        ST_LOCKED: if (keyHit && wrData == KEY_FIRST) stateD = ST_MID;
        ST_MID:    stateD = (keyHit && wrData == KEY_SECOND) ? ST_OPEN : ST_LOCKED;
        default:   stateD = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_LOCKED;
    else       stateQ <= stateD;
  end

  assign strobes.state     = stateQ;
  assign strobes.writeOpen = (stateQ == ST_OPEN);

  p_first_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LOCKED && keyHit && wrData == KEY_FIRST) |=> (stateQ == ST_MID));
  p_second_key_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_MID && keyHit && wrData == KEY_SECOND) |=> (stateQ == ST_OPEN));
  p_mid_abort_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_MID && wrEn && !(keyHit && wrData == KEY_SECOND)) |=> (stateQ == ST_LOCKED));
  p_open_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OPEN && wrEn) |=> (stateQ == ST_LOCKED));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(stateQ));
  p_legal_state_r12: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != 2'd3);
endmodule

// File: rtl/keyGuardPath.sv
module keyGuardPath
  import key_guard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 8,
  parameter int KEY_ADDR = 12,
  parameter int LOCK_IDX = 1,
  parameter logic [NUM_REGS-1:0] STICKY_MASK = 8'hF6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic                lockDataBit,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  ctrlStrobe_t         strobes,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_REGS-1:0] wrAllow,
  output logic                stickyLock
);
  localparam logic [ADDR_W-1:0] KeyAddrL  = ADDR_W'(KEY_ADDR);
  localparam logic [ADDR_W-1:0] LockAddrL = ADDR_W'(LOCK_IDX);

  logic stickyQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_allow
    logic blockedHere;
    assign blockedHere = STICKY_MASK[i] && stickyQ;
    assign wrAllow[i] = wrEn && strobes.writeOpen && !blockedHere
                        && (wrAddr == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyQ <= 1'b0;
    else if (wrAllow[LOCK_IDX] && lockDataBit) stickyQ <= 1'b1;
  end

  assign stickyLock = stickyQ;

  always_comb begin
    rdData = '0;
    if (rdAddr == KeyAddrL)       rdData[1:0] = strobes.state;
    else if (rdAddr == LockAddrL) rdData[DATA_W-1] = stickyQ;
  end

  p_allow_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrAllow));
  p_allow_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (wrAllow == '0));
  p_allow_open_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrAllow != '0) |-> (strobes.state == ST_OPEN));
  p_sticky_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    stickyQ |-> ((wrAllow & STICKY_MASK) == '0));
  p_sticky_keep_r11: assert property (@(posedge clk) disable iff (!rstN)
    stickyQ |=> stickyQ);
  p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyQ) |-> $past(wrEn && strobes.writeOpen && wrAddr == LockAddrL));
endmodule

// File: rtl/keyGuard.sv
module keyGuard
  import key_guard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 8,
  parameter int KEY_ADDR = 12,
  parameter int LOCK_IDX = 1,
  parameter logic [NUM_REGS-1:0] STICKY_MASK = 8'hF6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_REGS-1:0] wrAllow,
  output logic                stickyLock
);
  ctrlStrobe_t strobes;

  keyGuardCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strobes(strobes)
  );

  keyGuardPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .KEY_ADDR(KEY_ADDR), .LOCK_IDX(LOCK_IDX), .STICKY_MASK(STICKY_MASK)
  ) u_path (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .lockDataBit(wrData[DATA_W-1]), .rdAddr(rdAddr), .strobes(strobes),
    .rdData(rdData), .wrAllow(wrAllow), .stickyLock(stickyLock)
  );
endmodule

// File: tb/keyGuard_test.sv
module keyGuard_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [7:0]  wrAllow;
  logic        stickyLock;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  localparam logic [3:0]  KEY = 4'd12;
  localparam logic [31:0] K1 = 32'h0000_00A5;
  localparam logic [31:0] K2 = 32'h0000_00F1;

  always #5 clk = ~clk;

  keyGuard uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wrAllow(wrAllow), .stickyLock(stickyLock)
  );

  // Monitor: samples before the rising edge while a write is presented.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (wrEn) begin
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL monitor: write seen with empty queue, actual=%h expected=none", wrAllow);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checks++;
          if (wrAllow !== e) begin
            errors++;
            $display("FAIL %s: wrAllow actual=%b expected=%b", t, wrAllow, e);
          end
        end
      end
    end
  end

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d,
                         input logic [7:0] exp, input string tag);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic checkRead(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rdAddr = a;
    #2;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: rdData@%0d actual=%h expected=%h", tag, a, rdData, exp);
    end
    checks++;
    if (wrAllow !== 8'h00) begin
      errors++;
      $display("FAIL R8: wrAllow with no strobe actual=%b expected=00000000", wrAllow);
    end
  endtask

  task automatic unlock(input string tag);
    doWrite(KEY, K1, 8'h00, tag);
    doWrite(KEY, K2, 8'h00, tag);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkRead(KEY, 32'h0, "R1 state");
    checkRead(4'd1, 32'h0, "R1 sticky");
    // R7 locked writes refused
    doWrite(4'd0, 32'h1234, 8'h00, "R7 locked reg write");
    doWrite(KEY, 32'h5A, 8'h00, "R7 wrong key");
    checkRead(KEY, 32'h0, "R7 state stays");
    doWrite(KEY, 32'h0100_00A5, 8'h00, "R7 key with upper bits");
    checkRead(KEY, 32'h0, "R7 full-word key");
    // R2, R3
    doWrite(KEY, K1, 8'h00, "R2 first key");
    checkRead(KEY, 32'h1, "R2 intermediate");
    checkRead(4'd9, 32'h0, "R12 other address");
    doWrite(KEY, K2, 8'h00, "R3 second key");
    checkRead(KEY, 32'h2, "R3 open");
    // R5 one write then relock
    doWrite(4'd3, 32'hABCD, 8'h08, "R5 open write idx3");
    checkRead(KEY, 32'h0, "R5 relocked");
    doWrite(4'd3, 32'hABCD, 8'h00, "R5 second write refused");
    // R6
    unlock("R6 setup");
    doWrite(KEY, K1, 8'h00, "R6 key write while open");
    checkRead(KEY, 32'h0, "R6 relocked not mid");
    // R4
    doWrite(KEY, K1, 8'h00, "R4 setup");
    doWrite(KEY, 32'h33, 8'h00, "R4 bad second key");
    checkRead(KEY, 32'h0, "R4 back to locked");
    doWrite(KEY, K1, 8'h00, "R4 setup");
    doWrite(4'd2, 32'h77, 8'h00, "R4 reg write while mid");
    checkRead(KEY, 32'h0, "R4 reg write relocks");
    // R5 unmapped address still consumes opening
    unlock("R5 setup");
    doWrite(4'd9, 32'h1, 8'h00, "R5 unmapped write");
    checkRead(KEY, 32'h0, "R5 unmapped relocks");
    unlock("R5 setup");
    doWrite(4'd7, 32'h1, 8'h80, "R5 open write idx7");
    // R9 coincident relock and sticky set
    unlock("R9 setup");
    doWrite(4'd1, 32'h8000_0000, 8'h02, "R9 lock write allowed");
    checkRead(4'd1, 32'h8000_0000, "R9 sticky readback");
    checkRead(KEY, 32'h0, "R9 key relocked");
    // R10
    unlock("R10 setup");
    doWrite(4'd2, 32'h5, 8'h00, "R10 masked idx2 refused");
    checkRead(KEY, 32'h0, "R10 refused write relocks");
    unlock("R10 setup");
    doWrite(4'd0, 32'h5, 8'h01, "R10 unmasked idx0 allowed");
    unlock("R10 setup");
    doWrite(4'd5, 32'h5, 8'h00, "R10 masked idx5 refused");
    unlock("R10 setup");
    doWrite(4'd3, 32'h5, 8'h08, "R10 unmasked idx3 allowed");
    // R11
    unlock("R11 setup");
    doWrite(4'd1, 32'h0, 8'h00, "R11 clear attempt refused");
    checkRead(4'd1, 32'h8000_0000, "R11 sticky holds");
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkRead(4'd1, 32'h0, "R11 cleared by reset");
    checkRead(KEY, 32'h0, "R1 state after reset");
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL monitor: unconsumed items actual=%0d expected=0", expQ.size());
    end
    summary();
  end
endmodule